// File: doc/BRIEF.md
# Masked Content-Addressable Memory Controller

This block is a small content-addressable memory of 32-bit words. Each word has its own valid bit. A synchronous command port drives the block with one command per clock. The commands load the internal registers, search the table, write words and read results back. The register set holds a search key, seven selectable bit masks, a configuration word, a 12-bit indirect pointer and a result status.

A search compares the key with every valid word in parallel. Bits marked in the chosen mask are left out of the comparison. The result is an active-low hit flag, an active-low flag for two or more hits, and the index of the lowest-numbered hit, which has the highest priority. Writes use the same masks, so a masked bit keeps its old value. There are three write forms: by explicit address, through the pointer (with optional post-increment or post-decrement), and into the lowest-numbered free slot. An active-low full flag reports a table with no free slot, but only while the external full-in input is low.

Top module: `cam_ctrl`

## Requirements
- R1: While `rst` is high, all valid bits, the key, all masks, the configuration word and the pointer clear to zero. `match_n` and `mmatch_n` go high, `active_addr` goes to 0 and the result type goes to 00 (reset state).
- R2: A search uses mask `cmd_msel` (1..7). Select 0 means no mask. A mask bit of 1 leaves that bit out of the comparison, and a fully set mask matches every valid word. Invalid words never match. Loading mask select 0 is ignored.
- R3: After a search, `match_n` is low exactly when at least one valid word matches. `active_addr` is the lowest matching index, or 0 on a miss. The result type becomes 01.
- R4: After a search, `mmatch_n` is low exactly when two or more words match.
- R5: Op 5 searches with the stored key. Op 6 searches with `cmd_data` and leaves the key unchanged. Op 7 searches with `cmd_data` and also loads it as the key.
- R6: A direct write (op 8) stores `cmd_data` at `cmd_addr` under the mask chosen by configuration bits 31:29 (000 means unmasked) and sets that word valid. The result type becomes 10 and `active_addr` becomes the address. An address of DEPTH or more is ignored.
- R7: Indirect writes store data at the pointer under mask `cmd_msel` and set the word valid. Op 9 leaves the pointer as it is, op 10 increments it after the write and op 11 decrements it after the write. Op 18 reads the word at the pointer, or returns 0 when the pointer is out of range.
- R8: The pointer is 12 bits wide and loads from `cmd_data[11:0]`. Op 13 increments it and op 14 decrements it, wrapping modulo 4096. Reading it returns zeros above bit 11.
- R9: A next-free write (op 12) stores masked data into the lowest-indexed invalid word, sets it valid and reports it with result type 10. When every word is valid, the command changes neither the table nor the status.
- R10: `full_n` is low only when every word is valid and `full_in_n` is low. It follows `full_in_n` in the same cycle.
- R11: The status word has `match_n` at bit 31, `mmatch_n` at bit 30 and `full_n` at bit 29. Bits 25:24 hold the result type and bits 11:0 hold the active address. All other bits are 0.
- R12: The configuration word reads back exactly as written, including the bits with no function. Only bits 31:29 affect behaviour.
- R13: Opcodes are 0 none, 1 load key, 2 load mask, 3 load configuration, 4 load pointer, 15 read status, 16 read configuration and 17 read pointer. Every read command (15 to 18) raises `rd_valid` with `rd_data` in the following cycle, and `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 5 | Opcode |
| cmd_msel | input | 3 | Mask select for searches, indirect writes, next-free writes and mask loads |
| cmd_addr | input | 12 | Address for direct writes |
| cmd_data | input | 32 | Data bus |
| full_in_n | input | 1 | Active-low full-in input that gates the full flag |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| match_n | output | 1 | Active-low hit flag from the last search |
| mmatch_n | output | 1 | Active-low multiple-hit flag from the last search |
| full_n | output | 1 | Active-low full flag |
| active_addr | output | 12 | Active address from the last search or access |

## Verification
The bench aims at the priority when several words hit. A design that picked the highest index, or ignored valid bits, would report the wrong address under a fully set mask. Masked writes are read back word by word, so a design that wrote through masked bits would return the wrong value. The bench also checks that op 6 leaves the key alone and that loading mask 0 changes nothing. It walks the pointer across the 0/4095 wrap, and a design that kept stray upper bits would fail there. It fills the table in next-free order and then writes to the full table, which catches a design that overwrote an entry or moved the status. It toggles the full-in input, which catches a full flag that is not gated by that input.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int MSW     = 3;
    localparam int NMASK   = 7;
    localparam int WSEL_HI = 31;
    localparam int WSEL_LO = 29;

    typedef enum logic [4:0] {
        OP_NOP        = 5'd0,
        OP_LD_KEY     = 5'd1,
        OP_LD_MASK    = 5'd2,
        OP_LD_CFG     = 5'd3,
        OP_LD_PTR     = 5'd4,
        OP_SRCH       = 5'd5,
        OP_SRCH_BUS   = 5'd6,
        OP_SRCH_BUSLD = 5'd7,
        OP_WR_DIR     = 5'd8,
        OP_WR_PTR     = 5'd9,
        OP_WR_PTR_INC = 5'd10,
        OP_WR_PTR_DEC = 5'd11,
        OP_WR_FREE    = 5'd12,
        OP_PTR_INC    = 5'd13,
        OP_PTR_DEC    = 5'd14,
        OP_RD_STAT    = 5'd15,
        OP_RD_CFG     = 5'd16,
        OP_RD_PTR     = 5'd17,
        OP_RD_WORD    = 5'd18
    } cam_op_e;

    typedef enum logic [1:0] {
        RT_RESET = 2'b00,
        RT_HIT   = 2'b01,
        RT_MEM   = 2'b10,
        RT_TABLE = 2'b11
    } res_type_e;

    typedef struct packed {
        logic          match_n;
        logic          mmatch_n;
        res_type_e     rtype;
        logic [AW-1:0] aa;
    } cam_stat_t;

    function automatic logic [DW-1:0] pack_status(cam_stat_t s, logic full_n);
        logic [DW-1:0] w;
        w          = '0;
        w[31]      = s.match_n;
        w[30]      = s.mmatch_n;
        w[29]      = full_n;
        w[25:24]   = s.rtype;
        w[AW-1:0]  = s.aa;
        return w;
    endfunction

    function automatic logic [DW-1:0] merge_masked(logic [DW-1:0] old_w,
                                                   logic [DW-1:0] new_w,
                                                   logic [DW-1:0] keep);
        return (old_w & keep) | (new_w & ~keep);
    endfunction
endpackage

// File: rtl/cam_prienc.sv
module cam_prienc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    wr_keep,
    input  logic [DW-1:0]    key,
    input  logic [DW-1:0]    key_ign,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_word,
    output logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] valid_vec
);
    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] data_q;
        logic          vld_q;
        logic          sel;

        assign sel = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
            end else if (sel) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) data_q <= merge_masked(data_q, wr_data, wr_keep);
        end

        assign words[g]     = data_q;
        assign valid_vec[g] = vld_q;
        assign hit_vec[g]   = vld_q && (((data_q ^ key) & ~key_ign) == '0);
    end

    assign rd_word = words[rd_idx];
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import cam_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [4:0]    cmd_op,
    input  logic [2:0]    cmd_msel,
    input  logic [11:0]   cmd_addr,
    input  logic [31:0]   cmd_data,
    input  logic          full_in_n,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic          match_n,
    output logic          mmatch_n,
    output logic          full_n,
    output logic [11:0]   active_addr
);
    localparam int IW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    cam_op_e          op;
    logic [DW-1:0]    key_q, cfg_q;
    logic [DW-1:0]    mask_q [NMASK+1];
    logic [AW-1:0]    ptr_q;
    cam_stat_t        st_q;
    logic             rd_valid_q;
    logic [DW-1:0]    rd_data_q;

    logic [DW-1:0]    sel_mask, dir_mask, key, wr_keep, rd_word;
    logic [DEPTH-1:0] hit_vec, valid_vec;
    logic             hit_any, hit_multi, free_any, wr_go, ptr_in;
    logic [IW-1:0]    hit_idx, free_idx;
    logic [AW-1:0]    tgt;

    assign op       = cam_op_e'(cmd_op);
    assign sel_mask = mask_q[cmd_msel];
    assign dir_mask = mask_q[cfg_q[WSEL_HI:WSEL_LO]];
    assign key      = (op == OP_SRCH) ? key_q : cmd_data;
    assign ptr_in   = (32'(ptr_q) < DEPTH);

    always_comb begin
        tgt     = ptr_q;
        wr_keep = sel_mask;
        wr_go   = 1'b0;
        unique case (op)
            OP_WR_DIR: begin
                tgt     = cmd_addr;
                wr_keep = dir_mask;
                wr_go   = (32'(cmd_addr) < DEPTH);
            end
            OP_WR_PTR, OP_WR_PTR_INC, OP_WR_PTR_DEC: wr_go = ptr_in;
            OP_WR_FREE: begin
                tgt   = AW'(free_idx);
                wr_go = free_any;
            end
            default: ;
        endcase
    end

    cam_array #(.DEPTH(DEPTH), .IW(IW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd_valid && wr_go),
        .wr_idx   (tgt[IW-1:0]),
        .wr_data  (cmd_data),
        .wr_keep  (wr_keep),
        .key      (key),
        .key_ign  (sel_mask),
        .rd_idx   (ptr_q[IW-1:0]),
        .rd_word  (rd_word),
        .hit_vec  (hit_vec),
        .valid_vec(valid_vec)
    );

    cam_prienc #(.N(DEPTH), .IW(IW)) u_hit_enc (
        .vec(hit_vec), .any(hit_any), .idx(hit_idx)
    );

    cam_prienc #(.N(DEPTH), .IW(IW)) u_free_enc (
        .vec(~valid_vec), .any(free_any), .idx(free_idx)
    );

    assign hit_multi = |(hit_vec & (hit_vec - {{(DEPTH-1){1'b0}}, 1'b1}));
    assign full_n    = ~((&valid_vec) & ~full_in_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q      <= '0;
            cfg_q      <= '0;
            ptr_q      <= '0;
            for (int m = 0; m <= NMASK; m++) mask_q[m] <= '0;
            st_q       <= '{match_n: 1'b1, mmatch_n: 1'b1, rtype: RT_RESET, aa: '0};
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            if (cmd_valid) begin
                unique case (op)
                    OP_LD_KEY:  key_q <= cmd_data;
                    OP_LD_MASK: if (cmd_msel != '0) mask_q[cmd_msel] <= cmd_data;
                    OP_LD_CFG:  cfg_q <= cmd_data;
                    OP_LD_PTR:  ptr_q <= cmd_data[AW-1:0];
                    OP_SRCH, OP_SRCH_BUS, OP_SRCH_BUSLD: begin
                        st_q.match_n  <= ~hit_any;
                        st_q.mmatch_n <= ~hit_multi;
                        st_q.rtype    <= RT_HIT;
                        st_q.aa       <= hit_any ? AW'(hit_idx) : '0;
                        if (op == OP_SRCH_BUSLD) key_q <= cmd_data;
                    end
                    OP_WR_DIR, OP_WR_PTR, OP_WR_PTR_INC, OP_WR_PTR_DEC, OP_WR_FREE: begin
                        if (wr_go) begin
                            st_q.rtype <= RT_MEM;
                            st_q.aa    <= tgt;
                        end
                        if (op == OP_WR_PTR_INC) ptr_q <= ptr_q + 1'b1;
                        if (op == OP_WR_PTR_DEC) ptr_q <= ptr_q - 1'b1;
                    end
                    OP_PTR_INC: ptr_q <= ptr_q + 1'b1;
                    OP_PTR_DEC: ptr_q <= ptr_q - 1'b1;
                    OP_RD_STAT: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= pack_status(st_q, full_n);
                    end
                    OP_RD_CFG: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= cfg_q;
                    end
                    OP_RD_PTR: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= DW'(ptr_q);
                    end
                    OP_RD_WORD: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= ptr_in ? rd_word : '0;
                        if (ptr_in) begin
                            st_q.rtype <= RT_MEM;
                            st_q.aa    <= ptr_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;
    assign match_n     = st_q.match_n;
    assign mmatch_n    = st_q.mmatch_n;
    assign active_addr = st_q.aa;
endmodule

// File: rtl/cam_ctrl_chk.sv
module cam_ctrl_chk #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [4:0]       cmd_op,
    input logic             full_in_n,
    input logic             rd_valid,
    input logic             match_n,
    input logic             mmatch_n,
    input logic             full_n,
    input logic [DEPTH-1:0] valid_vec,
    input logic [11:0]      ptr_q,
    input logic [1:0]       rtype
);
    logic is_rd;
    assign is_rd = cmd_valid && (cmd_op >= 5'd15) && (cmd_op <= 5'd18);

    AST_RESET_STATE: assert property (@(posedge clk)
        $fell(rst) |-> (rtype == 2'b00 && match_n && mmatch_n && valid_vec == '0)); // R1
    AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (rst)
        !mmatch_n |-> !match_n); // R4
    AST_FULL_GATED: assert property (@(posedge clk) disable iff (rst)
        full_in_n |-> full_n); // R10
    AST_FULL_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (&valid_vec)); // R10
    AST_PTR_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 5'd13) |=> (ptr_q == 12'($past(ptr_q) + 1'b1))); // R8
    AST_FULL_WRITE_NOOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 5'd12 && (&valid_vec)) |=> $stable(valid_vec)); // R9
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid); // R13
    AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> !rd_valid); // R13
endmodule

bind cam_ctrl cam_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .full_in_n(full_in_n),
    .rd_valid (rd_valid),
    .match_n  (match_n),
    .mmatch_n (mmatch_n),
    .full_n   (full_n),
    .valid_vec(valid_vec),
    .ptr_q    (ptr_q),
    .rtype    (st_q.rtype)
);

// File: tb/sim_cam_ctrl.sv
module sim_cam_ctrl;
    import cam_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_op = '0;
    logic [2:0]  cmd_msel = '0;
    logic [11:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic        full_in_n = 1'b0;
    logic        rd_valid, match_n, mmatch_n, full_n;
    logic [31:0] rd_data;
    logic [11:0] active_addr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] A = 32'hA5A5_0001;
    localparam logic [31:0] B = 32'h1234_5678;
    localparam logic [31:0] C = 32'hCAFE_0010;
    localparam logic [31:0] D = 32'h0D0D_0D0D;
    localparam logic [31:0] E = 32'hEEEE_0000;

    cam_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_msel(cmd_msel), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .full_in_n(full_in_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .match_n(match_n), .mmatch_n(mmatch_n), .full_n(full_n),
        .active_addr(active_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic issue(cam_op_e op, logic [2:0] ms, logic [11:0] a, logic [31:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_msel  = ms;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // driver: push the expected word, then issue the read
    task automatic rd(cam_op_e op, logic [31:0] exp, string r);
        exp_q.push_back(exp);
        tag_q.push_back(r);
        issue(op, 3'd0, 12'd0, 32'd0);
    endtask

    task automatic srch(cam_op_e op, logic [2:0] ms, logic [31:0] d,
                        logic em, logic emm, logic [11:0] ea, string r);
        issue(op, ms, 12'd0, d);
        chk({r, " match_n"}, 32'(match_n), 32'(em));
        chk({r, " mmatch_n"}, 32'(mmatch_n), 32'(emm));
        chk({r, " active_addr"}, 32'(active_addr), 32'(ea));
    endtask

    // monitor: pop and compare each read result
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R13 unexpected read actual=%h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 match_n", 32'(match_n), 32'd1);
        chk("R1 mmatch_n", 32'(mmatch_n), 32'd1);
        chk("R1 active_addr", 32'(active_addr), 32'd0);
        chk("R10 full_n empty", 32'(full_n), 32'd1);
        rd(OP_RD_STAT, 32'hE000_0000, "R1 R11 status");
        rd(OP_RD_PTR, 32'd0, "R1 pointer");
        rd(OP_RD_CFG, 32'd0, "R1 config");

        // R12 reserved bits read back
        issue(OP_LD_CFG, 3'd0, 12'd0, 32'h0000_0AB5);
        rd(OP_RD_CFG, 32'h0000_0AB5, "R12 config");

        // R6 direct writes
        issue(OP_WR_DIR, 3'd0, 12'd3, A);
        issue(OP_WR_DIR, 3'd0, 12'd7, B);
        issue(OP_WR_DIR, 3'd0, 12'd9, A);
        rd(OP_RD_STAT, 32'hE200_0009, "R6 status after write");

        // R3 R4 priority and multiple hits
        issue(OP_LD_KEY, 3'd0, 12'd0, A);
        srch(OP_SRCH, 3'd0, 32'd0, 1'b0, 1'b0, 12'd3, "R3 R4 double hit");
        rd(OP_RD_STAT, 32'h2100_0003, "R11 status after search");

        // R5 key sources
        srch(OP_SRCH_BUS, 3'd0, B, 1'b0, 1'b1, 12'd7, "R5 bus search");
        srch(OP_SRCH, 3'd0, 32'd0, 1'b0, 1'b0, 12'd3, "R5 key kept");
        srch(OP_SRCH_BUSLD, 3'd0, B, 1'b0, 1'b1, 12'd7, "R5 bus load");
        srch(OP_SRCH, 3'd0, 32'd0, 1'b0, 1'b1, 12'd7, "R5 key loaded");

        // R2 masks
        issue(OP_LD_MASK, 3'd2, 12'd0, 32'h0000_00FF);
        srch(OP_SRCH_BUS, 3'd2, B ^ 32'h0000_00C3, 1'b0, 1'b1, 12'd7, "R2 masked hit");
        srch(OP_SRCH_BUS, 3'd0, B ^ 32'h0000_00C3, 1'b1, 1'b1, 12'd0, "R2 R3 unmasked miss");
        issue(OP_LD_MASK, 3'd0, 12'd0, 32'hFFFF_FFFF);
        srch(OP_SRCH_BUS, 3'd0, B ^ 32'h0000_00C3, 1'b1, 1'b1, 12'd0, "R2 select zero ignored");
        issue(OP_LD_MASK, 3'd7, 12'd0, 32'hFFFF_FFFF);
        srch(OP_SRCH_BUS, 3'd7, 32'h0, 1'b0, 1'b0, 12'd3, "R2 only valid words");

        // R6 masked direct write, out-of-range address
        issue(OP_LD_CFG, 3'd0, 12'd0, 32'h4000_0AB5);
        issue(OP_WR_DIR, 3'd0, 12'd7, 32'hFFFF_FFFF);
        issue(OP_LD_PTR, 3'd0, 12'd0, 32'd7);
        rd(OP_RD_WORD, 32'hFFFF_FF78, "R6 masked direct write");
        rd(OP_RD_CFG, 32'h4000_0AB5, "R12 config select");
        issue(OP_WR_DIR, 3'd0, 12'd20, 32'd0);
        rd(OP_RD_STAT, 32'h2200_0007, "R6 out of range ignored");

        // R7 indirect writes
        issue(OP_LD_PTR, 3'd0, 12'd0, 32'd10);
        issue(OP_WR_PTR_INC, 3'd0, 12'd0, C);
        rd(OP_RD_PTR, 32'd11, "R7 post increment");
        issue(OP_WR_PTR_DEC, 3'd0, 12'd0, D);
        rd(OP_RD_PTR, 32'd10, "R7 post decrement");
        issue(OP_PTR_DEC, 3'd0, 12'd0, 32'd0);
        rd(OP_RD_WORD, A, "R7 read word 9");
        issue(OP_PTR_INC, 3'd0, 12'd0, 32'd0);
        issue(OP_PTR_INC, 3'd0, 12'd0, 32'd0);
        rd(OP_RD_WORD, D, "R7 read word 11");
        issue(OP_LD_PTR, 3'd0, 12'd0, 32'd10);
        issue(OP_WR_PTR, 3'd2, 12'd0, 32'd0);
        rd(OP_RD_WORD, 32'h0000_0010, "R7 masked indirect write");

        // R8 pointer width and wrap
        issue(OP_LD_PTR, 3'd0, 12'd0, 32'hFFFF_FFFF);
        rd(OP_RD_PTR, 32'h0000_0FFF, "R8 upper bits zero");
        issue(OP_PTR_INC, 3'd0, 12'd0, 32'd0);
        rd(OP_RD_PTR, 32'd0, "R8 wrap up");
        issue(OP_PTR_DEC, 3'd0, 12'd0, 32'd0);
        rd(OP_RD_PTR, 32'h0000_0FFF, "R8 wrap down");

        // R9 next-free writes
        issue(OP_WR_FREE, 3'd0, 12'd0, E);
        rd(OP_RD_STAT, 32'h2200_0000, "R9 first free slot");
        srch(OP_SRCH_BUS, 3'd0, E, 1'b0, 1'b1, 12'd0, "R9 free write stored");
        for (int i = 0; i < 10; i++) begin
            if (i == 9) chk("R10 full_n one free", 32'(full_n), 32'd1);
            issue(OP_WR_FREE, 3'd0, 12'd0, 32'h7000_0000 + i);
        end
        chk("R10 full_n full", 32'(full_n), 32'd0);
        full_in_n = 1'b1;
        #1;
        chk("R10 full_n gated", 32'(full_n), 32'd1);
        full_in_n = 1'b0;
        @(negedge clk);
        rd(OP_RD_STAT, 32'h4200_000F, "R9 R11 last free slot");
        issue(OP_WR_FREE, 3'd0, 12'd0, 32'h5A5A_1234);
        rd(OP_RD_STAT, 32'h4200_000F, "R9 full write ignored");
        srch(OP_SRCH_BUS, 3'd0, 32'h5A5A_1234, 1'b1, 1'b1, 12'd0, "R9 full write not stored");
        srch(OP_SRCH_BUS, 3'd0, 32'h7000_0004, 1'b0, 1'b1, 12'd6, "R9 fill order");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R13 missing reads actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule